// File: doc/BRIEF.md
# Chained Two-Channel DAC Frame Writer

This block loads an X sample and a Y sample into two 10-bit serial DACs wired in a daisy chain. The two converters share one active-low chip select, one serial clock and one data line. A single start strobe latches both samples. The block then sends one framed burst of 32 serial clock pulses, most significant bit first. The word for the X converter goes out first, and the word for the Y converter follows it directly.

Each converter receives a 16-bit word. The word is four leading zero fill bits, then the ten sample bits from the most significant bit down, then two zero dummy bits. A parameter sets the serial clock rate as a half-period counted in system clock cycles. `busy_o` covers the length of a frame, and `done_o` pulses once when the frame is finished.

Top module: `dac_pair_frame_writer`

## Requirements
- R1: After reset, with no start given, `cs_n_o` is high and `sclk_o`, `sdo_o`, `busy_o` and `done_o` are all low.
- R2: The bits on `sdo_o` at the 32 rising edges of `sclk_o` form the value {4'b0000, X[9:0], 2'b00, 4'b0000, Y[9:0], 2'b00}. They are listed in the order sent, starting with bit 31 of that value.
- R3: Each frame has exactly 32 rising edges of `sclk_o`, and all of them occur while `cs_n_o` is low.
- R4: `sclk_o` is low while idle, and it is low in the cycle before and in the cycle of every change of `cs_n_o`.
- R5: `sdo_o` does not change while `sclk_o` is high. New data is presented only while the clock is low.
- R6: Every high phase of `sclk_o` lasts HALF_CYC system cycles. Every low phase inside a frame also lasts HALF_CYC system cycles.
- R7: `sdo_o` is low after the last data bit before `cs_n_o` rises, and it is low whenever `cs_n_o` is high.
- R8: X and Y are captured in the cycle of the start strobe. A start strobe, or a change of X or Y, while `busy_o` is high does not affect the frame in progress and does not cause an extra frame.
- R9: `busy_o` is high from the cycle after an accepted start until `cs_n_o` returns high. `done_o` is high for exactly one cycle: the cycle in which `cs_n_o` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe; accepted only while idle |
| x_i | input | 10 | Sample for the first converter in the chain |
| y_i | input | 10 | Sample for the second converter in the chain |
| cs_n_o | output | 1 | Shared chip select, active low |
| sclk_o | output | 1 | Shared serial clock, idles low |
| sdo_o | output | 1 | Shared serial data, MSB first |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The frame is tried with several kinds of sample pair:
- All zeros, to expose any fill or dummy bit driven high.
- All ones on both channels, to show that the bits at the 10-bit boundaries stay in place.
- One channel full and the other empty, to show whether the X and Y words are swapped.
- Alternating bit patterns, to catch bits shifted one place and repeated bits.

Random sample pairs cover the rest. Some frames are hit with a second start that carries different values partway through, to tell a block that captures its inputs from one that reads them live or restarts. After each frame the bench watches the idle line, to catch any frame that was queued.

// File: rtl/dacfw_pkg.sv
// Shared definitions for the chained DAC frame writer.
// Holds the sequencer state encoding used by the top module.
package dacfw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // chip select high, waiting for start
        ST_LOW  = 2'd1,   // clock low, data bit presented
        ST_HIGH = 2'd2,   // clock high, data bit sampled by the DACs
        ST_TAIL = 2'd3    // data parked low before chip select rises
    } seq_state_t;
endpackage

// File: rtl/dacfw_halfper_timer.sv
// Half-period timer: while run_i is high, tick_o pulses once every
// HALF_CYC system cycles. The count restarts from zero whenever
// run_i is low, so the first tick comes HALF_CYC cycles after run
// goes high. Assumes HALF_CYC >= 1.
module dacfw_halfper_timer #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    generate
        if (HALF_CYC <= 1) begin : g_every
            // With a one-cycle half-period every running cycle is a tick.
            assign tick_o = run_i;
        end else begin : g_count
            localparam int CW = $clog2(HALF_CYC);
            localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);
            logic [CW-1:0] cnt;

            // Counts cycles inside the current half-period.
            always_ff @(posedge clk) begin
                if (!rst_n || !run_i) cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else cnt <= cnt + 1'b1;
            end

            assign tick_o = run_i && (cnt == LAST);

            // R6
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/dacfw_frame_shifter.sv
// Frame shift register. It loads the whole frame in parallel,
// presents the MSB, and shifts one place left on each shift_i.
// last_o flags the final bit of the frame.
// Assumes load_i and shift_i are never high together.
module dacfw_frame_shifter #(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] load_val_i,
    input  logic               shift_i,
    output logic               msb_o,
    output logic               last_o
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] sreg;
    logic [CNT_W-1:0]   bit_idx;

    // Holds the frame and moves it toward the MSB one bit per shift.
    always_ff @(posedge clk) begin
        if (!rst_n) sreg <= '0;
        else if (load_i) sreg <= load_val_i;
        else if (shift_i) sreg <= {sreg[FRAME_W-2:0], 1'b0};
    end

    // Counts the bits already sent in this frame.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) bit_idx <= '0;
        else if (shift_i) bit_idx <= bit_idx + 1'b1;
    end

    assign msb_o  = sreg[FRAME_W-1];
    assign last_o = (bit_idx == LAST_IDX);

    // R3
    no_shift_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !shift_i);
endmodule

// File: rtl/dac_pair_frame_writer.sv
// Writes one X and one Y sample to two chained serial DACs in a
// single frame framed by chip select. Each device word is FILL_W
// zero bits, DATA_W sample bits MSB first and DUMMY_W zero bits.
// The X word is sent first. HALF_CYC sets each clock phase in
// system cycles. A start strobe is accepted only while idle.
module dac_pair_frame_writer #(
    parameter int DATA_W   = 10,
    parameter int FILL_W   = 4,
    parameter int DUMMY_W  = 2,
    parameter int HALF_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              sdo_o,
    output logic              busy_o,
    output logic              done_o
);
    import dacfw_pkg::*;

    localparam int WORD_W  = FILL_W + DATA_W + DUMMY_W;
    localparam int DEV_N   = 2;
    localparam int FRAME_W = DEV_N * WORD_W;

    seq_state_t state;
    logic       tick;
    logic       msb;
    logic       last_bit;
    logic       load;
    logic       shift;
    logic [FRAME_W-1:0] frame_word;

    // Builds the two device words, with the first device in the upper half.
    always_comb begin
        frame_word = {{FILL_W{1'b0}}, x_i, {DUMMY_W{1'b0}},
                      {FILL_W{1'b0}}, y_i, {DUMMY_W{1'b0}}};
    end

    assign load  = (state == ST_IDLE) && start_i;
    assign shift = (state == ST_HIGH) && tick && !last_bit;

    dacfw_halfper_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state != ST_IDLE),
        .tick_o (tick)
    );

    dacfw_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (frame_word),
        .shift_i    (shift),
        .msb_o      (msb),
        .last_o     (last_bit)
    );

    // Sequences chip select, the serial clock phases and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cs_n_o <= 1'b1;
            sclk_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: if (start_i) begin
                    cs_n_o <= 1'b0;
                    state  <= ST_LOW;
                end
                ST_LOW: if (tick) begin
                    sclk_o <= 1'b1;
                    state  <= ST_HIGH;
                end
                ST_HIGH: if (tick) begin
                    sclk_o <= 1'b0;
                    state  <= last_bit ? ST_TAIL : ST_LOW;
                end
                default: if (tick) begin
                    cs_n_o <= 1'b1;
                    done_o <= 1'b1;
                    state  <= ST_IDLE;
                end
            endcase
        end
    end

    assign sdo_o  = ((state == ST_LOW) || (state == ST_HIGH)) && msb;
    assign busy_o = (state != ST_IDLE);

    // R4
    cs_edge_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_n_o) |-> (!sclk_o && !$past(sclk_o)));
    // R3
    clock_inside_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !cs_n_o);
    // R7
    data_parked_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sdo_o);
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9
    done_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o && $past(!cs_n_o)));
    // R5
    data_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));
endmodule

// File: tb/dac_pair_frame_writer_test.sv
module dac_pair_frame_writer_test;
    localparam int HALF = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [9:0] x_in = '0;
    logic [9:0] y_in = '0;
    logic cs_n, sclk, sdo, busy, done;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit mon_on = 1'b0;

    always #4 clk = ~clk;

    dac_pair_frame_writer #(.HALF_CYC(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .x_i(x_in), .y_i(y_in),
        .cs_n_o(cs_n), .sclk_o(sclk), .sdo_o(sdo), .busy_o(busy), .done_o(done)
    );

    function automatic logic [31:0] expect_frame(input logic [9:0] x, input logic [9:0] y);
        logic [15:0] wx, wy;
        wx = 16'(x) << 2;
        wy = 16'(y) << 2;
        return {wx, wy};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Line monitor: everything is sampled on the falling clock edge.
    logic p_cs = 1'b1, p_sclk = 1'b0, p_sdo = 1'b0;
    logic [31:0] cap = '0;
    int rises = 0, run_len = 0, frames = 0, dones = 0;
    int v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r7 = 0, v_r9 = 0;

    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            run_len++;
            if (sclk && !p_sclk) begin
                if (cs_n) v_r3++;
                cap = {cap[30:0], sdo};
                rises++;
                if (run_len != HALF) v_r6++;
            end
            if (!sclk && p_sclk && run_len != HALF) v_r6++;
            if (sclk && p_sclk && sdo != p_sdo) v_r5++;
            if (cs_n != p_cs && (sclk || p_sclk)) v_r4++;
            if (cs_n && sdo) v_r7++;
            if (!cs_n && !busy) v_r9++;
            if (!cs_n && p_cs) begin cap = '0; rises = 0; end
            if (cs_n && !p_cs) begin
                if (p_sdo) v_r7++;
                if (run_len != HALF) v_r6++;
                if (!done) v_r9++;
                frames++;
            end
            if (done) begin
                dones++;
                if (!(cs_n && !p_cs)) v_r9++;
            end
            if (sclk != p_sclk || cs_n != p_cs) run_len = 0;
        end
        p_cs = cs_n; p_sclk = sclk; p_sdo = sdo;
    end

    task automatic send(input logic [9:0] x, input logic [9:0] y, input bit intrude);
        int f0, d0, guard;
        f0 = frames;
        d0 = dones;
        @(negedge clk);
        start = 1'b1; x_in = x; y_in = y;
        @(negedge clk);
        start = 1'b0;
        // R9: busy follows an accepted start by one cycle
        check(busy === 1'b1, "R9 busy after start", {31'b0, busy}, 32'd1);
        if (intrude) begin
            repeat (10 + $urandom_range(0, 120)) @(negedge clk);
            start = 1'b1; x_in = ~x; y_in = ~y;
            @(negedge clk);
            start = 1'b0; x_in = $urandom; y_in = $urandom;
        end
        guard = 0;
        while (frames == f0 && guard < 2000) begin @(negedge clk); guard++; end
        // R2: captured bit stream against the expected frame
        check(cap === expect_frame(x, y), "R2 frame bits", cap, expect_frame(x, y));
        // R3: exactly 32 clock pulses
        check(rises == 32, "R3 pulse count", 32'(rises), 32'd32);
        // R9: one done pulse, then idle
        @(negedge clk);
        check(dones == d0 + 1 && !busy && !done, "R9 done/busy", 32'(dones - d0), 32'd1);
        // R8: no queued frame follows
        repeat (40) @(negedge clk);
        check(frames == f0 + 1 && cs_n, "R8 no extra frame", 32'(frames - f0), 32'd1);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1: idle outputs after reset
        check(cs_n === 1'b1 && sclk === 1'b0 && sdo === 1'b0 && busy === 1'b0 && done === 1'b0,
              "R1 reset state", {27'b0, cs_n, sclk, sdo, busy, done}, 32'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        repeat (5) @(negedge clk);
        check(cs_n === 1'b1 && busy === 1'b0, "R1 idle after release", {30'b0, cs_n, busy}, 32'b10);
        send(10'h000, 10'h000, 1'b0);
        send(10'h3FF, 10'h3FF, 1'b0);
        send(10'h3FF, 10'h000, 1'b0);
        send(10'h000, 10'h3FF, 1'b1);
        send(10'h155, 10'h2AA, 1'b1);
        send(10'h201, 10'h001, 1'b0);
        for (int i = 0; i < 20; i++) send(10'($urandom), 10'($urandom), i[0]);
        check(v_r3 == 0, "R3 clock outside select", 32'(v_r3), 0);
        check(v_r4 == 0, "R4 clock low at select edge", 32'(v_r4), 0);
        check(v_r5 == 0, "R5 data steady while high", 32'(v_r5), 0);
        check(v_r6 == 0, "R6 phase width", 32'(v_r6), 0);
        check(v_r7 == 0, "R7 data parked low", 32'(v_r7), 0);
        check(v_r9 == 0, "R9 busy/done timing", 32'(v_r9), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        check(1'b0, "watchdog", 32'(cyc), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule